// File: doc/BRIEF.md
# Card Presence Debounce and Ready Flag

This block decides when a smart-card slot may be used. It watches two card-detect contacts of opposite polarity, one high when a card sits in the slot and one low when a card sits in the slot, and treats the card as inserted when either contact says so. A card must stay inserted for a long, tick-counted debounce window before a ready flag is raised towards the host. After the supply-detect reset releases, the block first sits out a power-on hold, also counted in ticks, and only then begins debouncing. A card already inserted at that point still has to wait the full debounce window.

While the flag is high, a card pull-out or any digital fault flag (supply undervoltage, overtemperature, card regulator fault, charge-pump fault) drops the flag on the next clock and emits a one-cycle alarm pulse that the activation sequencer uses to start shutting the card down. Pull-out is taken without debounce so that the shutdown begins at once. The flag stays low until a card is inserted and debounced, all faults are gone, and the host's active-low session command is back high. The host's return to idle serves as the acknowledgement.

A free-running prescaler produces the tick. Debounce length, power-on hold length and prescale ratio are parameters.

Top module: `card_ready_monitor`

## Requirements
- R1: The card counts as inserted when `det_hi_i` is 1 or `det_lo_n_i` is 0. With `det_hi_i`=0 and `det_lo_n_i`=1 it counts as absent and the ready flag never rises.
- R2: `ready_o` rises only after the two-flop synchronized insertion has held for DEB_TICKS prescaler ticks without a break. Any absence, however short, restarts the count from zero.
- R3: If a card is inserted when the power-on hold ends, the count starts only then. `ready_o` still waits the full debounce window after the hold.
- R4: During reset, and for POR_TICKS ticks after reset release, `ready_o` and `alarm_o` are 0.
- R5: While `ready_o` is 1, card pull-out drops `ready_o` on the first clock after the synchronized contact shows absence (three clock edges after the pin change), with no debounce, and raises `alarm_o` in the same cycle.
- R6: While `ready_o` is 1, any of `uv_flt_i`, `ot_flt_i`, `reg_flt_i`, `pump_flt_i` at 1 drops `ready_o` on the next clock edge and raises `alarm_o` in the same cycle.
- R7: Once dropped, `ready_o` returns to 1 only when all of the following hold: the card is inserted and debounced, no fault flag is set, and `cmd_n_i` is 1. While `cmd_n_i` is 0 it stays 0.
- R8: `alarm_o` is a single-cycle pulse and occurs only on the cycle that `ready_o` falls.
- R9: A fault flag raised while `ready_o` is already 0 produces no alarm and holds `ready_o` at 0. When the flag clears, `ready_o` rises on the next edge if R7 is met.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset from the supply detector |
| det_hi_i | input | 1 | Card-detect contact, high when a card is inserted (asynchronous) |
| det_lo_n_i | input | 1 | Card-detect contact, low when a card is inserted (asynchronous) |
| uv_flt_i | input | 1 | Supply undervoltage flag (synchronous) |
| ot_flt_i | input | 1 | Overtemperature flag (synchronous) |
| reg_flt_i | input | 1 | Card regulator fault flag (synchronous) |
| pump_flt_i | input | 1 | Charge-pump fault flag (synchronous) |
| cmd_n_i | input | 1 | Host session command, low = session requested, high = idle/acknowledge |
| ready_o | output | 1 | Slot ready flag |
| alarm_o | output | 1 | One-cycle alarm pulse to the activation sequencer |

## Verification
The assertions check the following relations on every cycle: the flag falls one edge after synchronized absence or a fault flag; every rise of the flag is preceded by a completed debounce, a high command line and no fault; the alarm is a lone pulse tied to a falling flag; the power-on hold keeps both outputs quiet. Only the bench scenarios can show how long things take and what their history is. These are: the debounce window length measured from a pin change, the restart after a short bounce, the full wait for a card inserted before the hold ends, each polarity combination of the two contacts, and the hold-off until the host releases its command after a fault.

// File: rtl/card_rdy_pkg.sv
package card_rdy_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,  // power-on hold, nothing decided yet
    ST_IDLE  = 2'd1,  // flag low, waiting for a good slot
    ST_READY = 2'd2   // flag high
  } rdy_state_t;

  // Card inserted when either contact reports it (opposite polarities).
  function automatic logic card_seen(input logic hi, input logic lo_n);
    return hi | ~lo_n;
  endfunction

  // Any of the electrical fault flags.
  function automatic logic any_fault(input logic [3:0] flags);
    return |flags;
  endfunction

endpackage

// File: rtl/crd_tick_gen.sv
module crd_tick_gen #(
  parameter int PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (PRESCALE <= 1) begin : g_every
      assign tick_o = rst_n;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R2
    end
  endgenerate

endmodule

// File: rtl/crd_pres_sync.sv
module crd_pres_sync
  import card_rdy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic det_hi_i,
  input  logic det_lo_n_i,
  output logic pres_o
);

  // Reset values correspond to "no card" on both contacts.
  logic [1:0] hi_q;
  logic [1:0] lo_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 2'b00;
      lo_n_q <= 2'b11;
    end else begin
      hi_q   <= {hi_q[0], det_hi_i};
      lo_n_q <= {lo_n_q[0], det_lo_n_i};
    end
  end

  assign pres_o = card_seen(hi_q[1], lo_n_q[1]);

endmodule

// File: rtl/crd_hold_cnt.sv
module crd_hold_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // Saturating step: stops at the limit.
  function automatic logic [CW-1:0] step(input logic [CW-1:0] v, input logic go);
    if (go && v != TOP) return v + 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= step(cnt_q, tick_i);
  end

  assign done_o = (cnt_q == TOP);

  AST_HOLD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);  // R2
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));  // R2

endmodule

// File: rtl/card_ready_monitor.sv
module card_ready_monitor
  import card_rdy_pkg::*;
#(
  parameter int PRESCALE  = 1000,
  parameter int DEB_TICKS = 8,
  parameter int POR_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_hi_i,
  input  logic det_lo_n_i,
  input  logic uv_flt_i,
  input  logic ot_flt_i,
  input  logic reg_flt_i,
  input  logic pump_flt_i,
  input  logic cmd_n_i,
  output logic ready_o,
  output logic alarm_o
);

  logic       tick;
  logic       pres_sync;
  logic       hold_done;
  logic       hold_active;
  logic       deb_clr;
  logic       deb_done;
  logic       flt_elec;
  logic       slot_good;
  logic       drop_evt;
  rdy_state_t state_q;
  logic       alarm_q;

  crd_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  crd_pres_sync u_sync (
    .clk(clk), .rst_n(rst_n),
    .det_hi_i(det_hi_i), .det_lo_n_i(det_lo_n_i),
    .pres_o(pres_sync)
  );

  crd_hold_cnt #(.LIMIT(POR_TICKS)) u_por (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(tick), .done_o(hold_done)
  );

  assign hold_active = ~hold_done;
  // Absence or power-on hold keeps the debounce at zero (R2, R3).
  assign deb_clr = ~pres_sync | hold_active;

  crd_hold_cnt #(.LIMIT(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .clr_i(deb_clr), .tick_i(tick), .done_o(deb_done)
  );

  assign flt_elec  = any_fault({pump_flt_i, reg_flt_i, ot_flt_i, uv_flt_i});
  assign slot_good = deb_done & pres_sync & ~flt_elec & cmd_n_i;
  assign drop_evt  = (state_q == ST_READY) & (flt_elec | ~pres_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= 1'b0;
      unique case (state_q)
        ST_HOLD:  if (hold_done) state_q <= ST_IDLE;
        ST_IDLE:  if (slot_good) state_q <= ST_READY;
        ST_READY: if (drop_evt) begin
                    state_q <= ST_IDLE;
                    alarm_q <= 1'b1;
                  end
        default:  state_q <= ST_HOLD;
      endcase
    end
  end

  assign ready_o = (state_q == ST_READY);
  assign alarm_o = alarm_q;

  AST_PULLOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_sync |=> !ready_o);  // R5
  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && flt_elec) |=> (!ready_o && alarm_o));  // R6
  AST_RISE_DEBOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(deb_done));  // R2
  AST_RISE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(cmd_n_i) && !$past(flt_elec)));  // R7
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (!ready_o && !alarm_o));  // R4
  AST_HOLD_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_done) |-> !deb_done);  // R3
  AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> !alarm_o);  // R8
  AST_ALARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> (!ready_o && $past(ready_o)));  // R8

endmodule

// File: tb/tb_card_ready_monitor.sv
module tb_card_ready_monitor;

  localparam int P   = 4;
  localparam int DEB = 5;
  localparam int POR = 6;
  localparam int LO_WIN = (DEB - 1) * P - 2;
  localparam int HI_WIN = (DEB + 1) * P + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_hi = 1'b0;
  logic det_lo_n = 1'b1;
  logic [3:0] flt = 4'b0;  // {pump, reg, ot, uv}
  logic cmd_n = 1'b1;
  logic ready, alarm;

  int checks = 0;
  int errors = 0;
  int alarm_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  card_ready_monitor #(.PRESCALE(P), .DEB_TICKS(DEB), .POR_TICKS(POR)) dut (
    .clk(clk), .rst_n(rst_n),
    .det_hi_i(det_hi), .det_lo_n_i(det_lo_n),
    .uv_flt_i(flt[0]), .ot_flt_i(flt[1]), .reg_flt_i(flt[2]), .pump_flt_i(flt[3]),
    .cmd_n_i(cmd_n), .ready_o(ready), .alarm_o(alarm)
  );

  always @(posedge clk) if (rst_n && alarm) alarm_cnt <= alarm_cnt + 1;

  // {det_hi, det_lo_n, expected inserted}
  localparam logic [2:0] VEC [4] = '{3'b010, 3'b111, 3'b001, 3'b101};

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic set_card(input logic on);
    det_hi   = on;
    det_lo_n = 1'b1;
  endtask

  initial begin
    int base;
    // R4 / R3: card inserted before reset release
    det_hi = 1'b1;
    wait_cyc(3);
    chk("R4 ready in reset", ready, 1'b0);
    chk("R4 alarm in reset", alarm, 1'b0);
    rst_n = 1'b1;
    wait_cyc(POR * P - 2);
    chk("R4 ready in hold", ready, 1'b0);
    wait_cyc(LO_WIN + 2);
    chk("R3 no credit during hold", ready, 1'b0);
    wait_cyc(HI_WIN - LO_WIN);
    chk("R3 ready after full debounce", ready, 1'b1);
    chk("R4 no alarm so far", alarm_cnt == 0, 1'b1);

    // R1: contact polarity table
    for (int i = 0; i < 4; i++) begin
      set_card(1'b0);
      wait_cyc(10);
      det_hi   = VEC[i][2];
      det_lo_n = VEC[i][1];
      wait_cyc(HI_WIN);
      chk($sformatf("R1 vector %0d", i), ready, VEC[i][0]);
    end

    // R5 / R8: pull-out without debounce
    set_card(1'b0);
    base = alarm_cnt;
    wait_cyc(2);
    chk("R5 ready before sync", ready, 1'b1);
    wait_cyc(1);
    chk("R5 ready dropped", ready, 1'b0);
    chk("R5 alarm raised", alarm, 1'b1);
    wait_cyc(1);
    chk("R8 alarm single cycle", alarm, 1'b0);
    chk("R8 one alarm", alarm_cnt == base + 1, 1'b1);

    // R2: bounce restarts the count
    wait_cyc(10);
    set_card(1'b1);
    wait_cyc(2 * P);
    set_card(1'b0);
    wait_cyc(2);
    set_card(1'b1);
    wait_cyc(LO_WIN);
    chk("R2 bounce restarted count", ready, 1'b0);
    wait_cyc(HI_WIN - LO_WIN);
    chk("R2 ready after clean window", ready, 1'b1);

    // R6 / R7: each fault flag, host holds session then acknowledges
    for (int f = 0; f < 4; f++) begin
      cmd_n = 1'b0;
      wait_cyc(2);
      flt[f] = 1'b1;
      wait_cyc(1);
      chk($sformatf("R6 fault %0d drops ready", f), ready, 1'b0);
      chk($sformatf("R6 fault %0d alarm", f), alarm, 1'b1);
      wait_cyc(1);
      chk("R8 alarm single cycle", alarm, 1'b0);
      flt[f] = 1'b0;
      wait_cyc(10);
      chk("R7 held low while cmd low", ready, 1'b0);
      cmd_n = 1'b1;
      wait_cyc(1);
      chk("R7 ready after acknowledge", ready, 1'b1);
    end

    // R9: fault while already idle
    set_card(1'b0);
    wait_cyc(6);
    base = alarm_cnt;
    flt[0] = 1'b1;
    set_card(1'b1);
    wait_cyc(HI_WIN);
    chk("R9 fault blocks ready", ready, 1'b0);
    chk("R9 no alarm while idle", alarm_cnt == base, 1'b1);
    flt[0] = 1'b0;
    wait_cyc(1);
    chk("R9 ready after fault clears", ready, 1'b1);

    // R4: reset mid-operation
    rst_n = 1'b0;
    wait_cyc(1);
    chk("R4 reset clears ready", ready, 1'b0);
    rst_n = 1'b1;
    wait_cyc(POR * P - 2);
    chk("R4 ready in second hold", ready, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule